// File: doc/BRIEF.md
# Banked Interrupt Controller Registers

This block gathers 72 level-sensitive interrupt sources: eight basic lines and two banks of 32 lines each. Each source is gated by its own enable bit. Software changes the enables only through paired set and clear registers, so a driver can touch one source without a read-modify-write. The block raises a single combined interrupt output whenever any enabled source is active.

Software reads a summary word first. This word reports the basic sources directly. It also carries a one-bit flag for each bank, which says that the bank holds an active line that is not covered by a shortcut bit. Finally, it has shortcut bits that copy eleven frequently used bank lines, so a handler can often find its source in a single read. The full bank pending words can be read when a flag is set. A control word at offset 0x0C is kept as plain storage.

Global numbering is 0 to 7 for the basic lines, 8 to 39 for bank one (bank bit = number − 8) and 40 to 71 for bank two (bank bit = number − 40). Register reads are combinational from the address. Writes take effect at the clock edge.

Top module: `bank_irq_ctrl`

## Requirements
- R1: After reset every enable bit and the control word are zero. Every defined address reads zero and `irq` is low, whatever the source inputs.
- R2: A write to 0x18 (basic), 0x10 (bank one) or 0x14 (bank two) sets the enable bits where the written word has ones. Zero bits leave their enables unchanged.
- R3: A write to 0x24 (basic), 0x1C (bank one) or 0x20 (bank two) clears the enable bits where the written word has ones. Zero bits leave their enables unchanged.
- R4: A read of a group's set address or its clear address returns that group's current enable mask. Enables change only on writes to those six addresses.
- R5: 0x04 reads bank-one source AND enable, and 0x08 reads the same for bank two. Writes to 0x04, 0x08 and 0x00 change no state.
- R6: Bits 7:0 of the summary word at 0x00 are the basic sources ANDed with their enables.
- R7: Summary bits 10..14 copy the enabled, active bank-one lines 7, 9, 10, 18 and 19 (bit 10 = line 7). Bits 15..20 copy the enabled, active bank-two lines 21, 22, 23, 24, 25 and 30 (bit 15 = line 21, bit 20 = line 30).
- R8: Summary bit 8 (bank one) and bit 9 (bank two) are set exactly when that bank has an enabled, active line outside its shortcut set.
- R9: Summary bits 31:21 always read zero.
- R10: `irq` is high exactly when the summary word is non-zero.
- R11: A write to 0x0C stores the full word and 0x0C reads it back. The stored value does not affect `irq` or any pending read.
- R12: Addresses outside 0x00..0x24 read zero, and writes to them change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Byte address of the register |
| bus_we | input | 1 | Write strobe for one cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| src_basic | input | 8 | Basic source levels |
| src_bank1 | input | 32 | Bank-one source levels |
| src_bank2 | input | 32 | Bank-two source levels |
| irq | output | 1 | Combined interrupt request |

## Verification
An enable bit that is stuck or written to the wrong group shows up within one cycle of the write, both at its set or clear address and in `irq` while its source is active. A wrong shortcut position or a wrong flag mask shows only in the summary word, and only for the single source that is misrouted. The bench therefore walks shortcut and non-shortcut lines in both banks. It then runs randomized writes and sources while a behavioural model is compared against the read port and `irq` on every cycle.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  // Register map (byte offsets); software decodes these.
  localparam int OFF_SUMMARY  = 'h00;
  localparam int OFF_PEND_B1  = 'h04;
  localparam int OFF_PEND_B2  = 'h08;
  localparam int OFF_CTRL     = 'h0C;
  localparam int OFF_SET_B1   = 'h10;
  localparam int OFF_SET_B2   = 'h14;
  localparam int OFF_SET_BAS  = 'h18;
  localparam int OFF_CLR_B1   = 'h1C;
  localparam int OFF_CLR_B2   = 'h20;
  localparam int OFF_CLR_BAS  = 'h24;

  // Shortcut lines copied into the summary word, lowest summary bit first.
  localparam int SC1_CNT = 5;
  localparam int SC2_CNT = 6;
  localparam int SC1_LINE [SC1_CNT] = '{7, 9, 10, 18, 19};
  localparam int SC2_LINE [SC2_CNT] = '{21, 22, 23, 24, 25, 30};
endpackage

// File: rtl/irqc_rst_sync.sv
module irqc_rst_sync (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic stage_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) begin
      stage_q   <= 1'b0;
      rst_n_out <= 1'b0;
    end else begin
      stage_q   <= 1'b1;
      rst_n_out <= stage_q;
    end
  end
endmodule

// File: rtl/irqc_enable_reg.sv
module irqc_enable_reg #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         set_en,
  input  logic         clr_en,
  input  logic [W-1:0] wmask,
  output logic [W-1:0] en_q
);
  logic [W-1:0] en_d;
  logic         upd;

  always_comb begin
    upd  = set_en | clr_en;
    en_d = en_q;
    if (set_en)      en_d = en_q | wmask;
    else if (clr_en) en_d = en_q & ~wmask;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   en_q <= '0;
    else if (upd) en_q <= en_d;
  end
endmodule

// File: rtl/irqc_load_reg.sv
module irqc_load_reg #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] din,
  output logic [W-1:0] q
);
  logic [W-1:0] d;

  always_comb d = din;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= '0;
    else if (load) q <= d;
  end
endmodule

// File: rtl/irqc_summary.sv
module irqc_summary
  import irqc_pkg::*;
#(
  parameter int NB = 8,
  parameter int BW = 32,
  parameter int DW = 32
) (
  input  logic [NB-1:0] pend_basic,
  input  logic [BW-1:0] pend_b1,
  input  logic [BW-1:0] pend_b2,
  output logic [DW-1:0] summary
);
  localparam int FLAG1   = NB;
  localparam int FLAG2   = NB + 1;
  localparam int SC1_LSB = NB + 2;
  localparam int SC2_LSB = SC1_LSB + SC1_CNT;

  logic [BW-1:0]      sc1_mask, sc2_mask;
  logic [SC1_CNT-1:0] sc1_bits;
  logic [SC2_CNT-1:0] sc2_bits;

  always_comb begin
    sc1_mask = '0;
    sc2_mask = '0;
    for (int k = 0; k < SC1_CNT; k++) sc1_mask[SC1_LINE[k]] = 1'b1;
    for (int k = 0; k < SC2_CNT; k++) sc2_mask[SC2_LINE[k]] = 1'b1;
  end

  for (genvar k = 0; k < SC1_CNT; k++) begin : g_sc1
    assign sc1_bits[k] = pend_b1[SC1_LINE[k]];
  end
  for (genvar k = 0; k < SC2_CNT; k++) begin : g_sc2
    assign sc2_bits[k] = pend_b2[SC2_LINE[k]];
  end

  always_comb begin
    summary                    = '0;
    summary[NB-1:0]            = pend_basic;
    summary[FLAG1]             = |(pend_b1 & ~sc1_mask);
    summary[FLAG2]             = |(pend_b2 & ~sc2_mask);
    summary[SC1_LSB +: SC1_CNT] = sc1_bits;
    summary[SC2_LSB +: SC2_CNT] = sc2_bits;
  end
endmodule

// File: rtl/bank_irq_ctrl.sv
module bank_irq_ctrl
  import irqc_pkg::*;
#(
  parameter int NUM_BASIC = 8,
  parameter int BANK_W    = 32,
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [NUM_BASIC-1:0] src_basic,
  input  logic [BANK_W-1:0] src_bank1,
  input  logic [BANK_W-1:0] src_bank2,
  output logic              irq
);
  logic                 rst_q_n;
  logic                 set_bas, set_b1, set_b2, clr_bas, clr_b1, clr_b2, ld_ctrl;
  logic [NUM_BASIC-1:0] en_basic_q;
  logic [BANK_W-1:0]    en_bank1_q, en_bank2_q;
  logic [NUM_BASIC-1:0] pend_basic;
  logic [BANK_W-1:0]    pend_b1, pend_b2;
  logic [DATA_W-1:0]    summary, ctrl_q;

  irqc_rst_sync u_rst (.clk(clk), .rst_n_in(rst_n), .rst_n_out(rst_q_n));

  // Write decode
  always_comb begin
    set_bas = bus_we && (bus_addr == ADDR_W'(OFF_SET_BAS));
    set_b1  = bus_we && (bus_addr == ADDR_W'(OFF_SET_B1));
    set_b2  = bus_we && (bus_addr == ADDR_W'(OFF_SET_B2));
    clr_bas = bus_we && (bus_addr == ADDR_W'(OFF_CLR_BAS));
    clr_b1  = bus_we && (bus_addr == ADDR_W'(OFF_CLR_B1));
    clr_b2  = bus_we && (bus_addr == ADDR_W'(OFF_CLR_B2));
    ld_ctrl = bus_we && (bus_addr == ADDR_W'(OFF_CTRL));
  end

  irqc_enable_reg #(.W(NUM_BASIC)) u_en_basic (
    .clk(clk), .rst_n(rst_q_n), .set_en(set_bas), .clr_en(clr_bas),
    .wmask(bus_wdata[NUM_BASIC-1:0]), .en_q(en_basic_q));

  irqc_enable_reg #(.W(BANK_W)) u_en_bank1 (
    .clk(clk), .rst_n(rst_q_n), .set_en(set_b1), .clr_en(clr_b1),
    .wmask(bus_wdata[BANK_W-1:0]), .en_q(en_bank1_q));

  irqc_enable_reg #(.W(BANK_W)) u_en_bank2 (
    .clk(clk), .rst_n(rst_q_n), .set_en(set_b2), .clr_en(clr_b2),
    .wmask(bus_wdata[BANK_W-1:0]), .en_q(en_bank2_q));

  irqc_load_reg #(.W(DATA_W)) u_ctrl (
    .clk(clk), .rst_n(rst_q_n), .load(ld_ctrl), .din(bus_wdata), .q(ctrl_q));

  always_comb begin
    pend_basic = src_basic & en_basic_q;
    pend_b1    = src_bank1 & en_bank1_q;
    pend_b2    = src_bank2 & en_bank2_q;
  end

  irqc_summary #(.NB(NUM_BASIC), .BW(BANK_W), .DW(DATA_W)) u_sum (
    .pend_basic(pend_basic), .pend_b1(pend_b1), .pend_b2(pend_b2),
    .summary(summary));

  always_comb irq = |summary;

  // Read mux
  always_comb begin
    bus_rdata = '0;
    if (bus_addr == ADDR_W'(OFF_SUMMARY))      bus_rdata = summary;
    else if (bus_addr == ADDR_W'(OFF_PEND_B1)) bus_rdata[BANK_W-1:0] = pend_b1;
    else if (bus_addr == ADDR_W'(OFF_PEND_B2)) bus_rdata[BANK_W-1:0] = pend_b2;
    else if (bus_addr == ADDR_W'(OFF_CTRL))    bus_rdata = ctrl_q;
    else if (bus_addr == ADDR_W'(OFF_SET_B1) || bus_addr == ADDR_W'(OFF_CLR_B1))
      bus_rdata[BANK_W-1:0] = en_bank1_q;
    else if (bus_addr == ADDR_W'(OFF_SET_B2) || bus_addr == ADDR_W'(OFF_CLR_B2))
      bus_rdata[BANK_W-1:0] = en_bank2_q;
    else if (bus_addr == ADDR_W'(OFF_SET_BAS) || bus_addr == ADDR_W'(OFF_CLR_BAS))
      bus_rdata[NUM_BASIC-1:0] = en_basic_q;
  end
endmodule

// File: rtl/bank_irq_ctrl_chk.sv
module bank_irq_ctrl_chk
  import irqc_pkg::*;
#(
  parameter int NUM_BASIC = 8,
  parameter int BANK_W    = 32,
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 32
) (
  input logic                 clk,
  input logic                 rst_q_n,
  input logic [ADDR_W-1:0]    bus_addr,
  input logic                 bus_we,
  input logic [DATA_W-1:0]    bus_wdata,
  input logic [DATA_W-1:0]    bus_rdata,
  input logic [NUM_BASIC-1:0] src_basic,
  input logic [BANK_W-1:0]    src_bank1,
  input logic [BANK_W-1:0]    src_bank2,
  input logic                 irq,
  input logic [NUM_BASIC-1:0] en_basic_q,
  input logic [BANK_W-1:0]    en_bank1_q,
  input logic [BANK_W-1:0]    en_bank2_q
);
  assert_set_basic_R2: assert property (@(posedge clk) disable iff (!rst_q_n)
    (bus_we && bus_addr == ADDR_W'(OFF_SET_BAS)) |=>
      ((en_basic_q & $past(bus_wdata[NUM_BASIC-1:0])) == $past(bus_wdata[NUM_BASIC-1:0])));

  assert_clr_bank1_R3: assert property (@(posedge clk) disable iff (!rst_q_n)
    (bus_we && bus_addr == ADDR_W'(OFF_CLR_B1)) |=>
      ((en_bank1_q & $past(bus_wdata[BANK_W-1:0])) == '0));

  assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_q_n)
    !bus_we |=> ($stable(en_basic_q) && $stable(en_bank1_q) && $stable(en_bank2_q)));

  assert_pend_b2_R5: assert property (@(posedge clk) disable iff (!rst_q_n)
    (bus_addr == ADDR_W'(OFF_PEND_B2)) |-> (bus_rdata[BANK_W-1:0] == (src_bank2 & en_bank2_q)));

  assert_upper_zero_R9: assert property (@(posedge clk) disable iff (!rst_q_n)
    (bus_addr == ADDR_W'(OFF_SUMMARY)) |-> (bus_rdata[DATA_W-1:21] == '0));

  assert_irq_R10: assert property (@(posedge clk) disable iff (!rst_q_n)
    irq == ((|(src_basic & en_basic_q)) || (|(src_bank1 & en_bank1_q)) ||
            (|(src_bank2 & en_bank2_q))));
endmodule

bind bank_irq_ctrl bank_irq_ctrl_chk #(
  .NUM_BASIC(NUM_BASIC), .BANK_W(BANK_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
) u_chk (
  .clk(clk), .rst_q_n(rst_q_n), .bus_addr(bus_addr), .bus_we(bus_we),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .src_basic(src_basic),
  .src_bank1(src_bank1), .src_bank2(src_bank2), .irq(irq),
  .en_basic_q(en_basic_q), .en_bank1_q(en_bank1_q), .en_bank2_q(en_bank2_q));

// File: tb/bank_irq_ctrl_bench.sv
`timescale 1ns/1ps
module bank_irq_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [7:0]  src_basic = '0;
  logic [31:0] src_bank1 = '0;
  logic [31:0] src_bank2 = '0;
  logic        irq;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 0;

  // Behavioural reference state
  logic [7:0]  m_enb = '0;
  logic [31:0] m_en1 = '0, m_en2 = '0, m_ctrl = '0;
  int sc1 [5] = '{7, 9, 10, 18, 19};
  int sc2 [6] = '{21, 22, 23, 24, 25, 30};

  always #10 clk = ~clk;

  bank_irq_ctrl u_bank_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .src_basic(src_basic),
    .src_bank1(src_bank1), .src_bank2(src_bank2), .irq(irq));

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (!rst_n) begin
      m_enb <= '0; m_en1 <= '0; m_en2 <= '0; m_ctrl <= '0;
    end else if (bus_we) begin
      case (bus_addr)
        8'h18: m_enb  <= m_enb | bus_wdata[7:0];
        8'h24: m_enb  <= m_enb & ~bus_wdata[7:0];
        8'h10: m_en1  <= m_en1 | bus_wdata;
        8'h1C: m_en1  <= m_en1 & ~bus_wdata;
        8'h14: m_en2  <= m_en2 | bus_wdata;
        8'h20: m_en2  <= m_en2 & ~bus_wdata;
        8'h0C: m_ctrl <= bus_wdata;
        default: ;
      endcase
    end
  end

  function automatic bit in_list1(int n);
    foreach (sc1[i]) if (sc1[i] == n) return 1;
    return 0;
  endfunction
  function automatic bit in_list2(int n);
    foreach (sc2[i]) if (sc2[i] == n) return 1;
    return 0;
  endfunction

  function automatic logic [31:0] model_summary();
    logic [31:0] s = '0;
    logic [31:0] p1 = src_bank1 & m_en1;
    logic [31:0] p2 = src_bank2 & m_en2;
    s[7:0] = src_basic & m_enb;
    for (int n = 0; n < 32; n++) begin
      if (p1[n] && !in_list1(n)) s[8] = 1'b1;
      if (p2[n] && !in_list2(n)) s[9] = 1'b1;
    end
    foreach (sc1[i]) s[10 + i] = p1[sc1[i]];
    foreach (sc2[i]) s[15 + i] = p2[sc2[i]];
    return s;
  endfunction

  function automatic logic [31:0] model_read(logic [7:0] a);
    case (a)
      8'h00: return model_summary();
      8'h04: return src_bank1 & m_en1;
      8'h08: return src_bank2 & m_en2;
      8'h0C: return m_ctrl;
      8'h10, 8'h1C: return m_en1;
      8'h14, 8'h20: return m_en2;
      8'h18, 8'h24: return {24'h0, m_enb};
      default: return '0;
    endcase
  endfunction

  function automatic string tag_for(logic [7:0] a);
    case (a)
      8'h00: return "R6 R7 R8 R9";
      8'h04, 8'h08: return "R5";
      8'h0C: return "R11";
      8'h10, 8'h14, 8'h18: return "R2 R4";
      8'h1C, 8'h20, 8'h24: return "R3 R4";
      default: return "R12";
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  // Every-cycle comparison against the model
  always @(negedge clk) begin
    if (cyc > 0 && !done) begin
      chk(tag_for(bus_addr), bus_rdata, model_read(bus_addr));
      chk("R10 irq", {31'b0, irq}, {31'b0, |model_summary()});
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    bus_addr = a; bus_we = 1'b1; bus_wdata = d;
    @(posedge clk); #1;
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input string tag, input logic [31:0] exp);
    bus_addr = a;
    @(negedge clk);
    chk(tag, bus_rdata, exp);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    src_basic = 8'hFF; src_bank1 = '1; src_bank2 = '1;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #1;
    // R1: reset state
    rd(8'h00, "R1 summary", 32'h0);
    rd(8'h10, "R1 enable", 32'h0);
    rd(8'h0C, "R1 ctrl", 32'h0);
    chk("R1 irq", {31'b0, irq}, 32'h0);

    wr(8'h18, 32'h05);
    rd(8'h00, "R2 R6 basic", 32'h05);
    wr(8'h18, 32'h02);
    rd(8'h18, "R2 set keeps", 32'h07);
    wr(8'h24, 32'h01);
    rd(8'h24, "R3 R4 clr read", 32'h06);
    rd(8'h18, "R3 R4 set read", 32'h06);
    wr(8'h24, 32'h06);

    wr(8'h10, 32'h88);
    rd(8'h04, "R5 bank1 pend", 32'h88);
    rd(8'h00, "R7 R8 line7 line3", 32'h500);
    wr(8'h1C, 32'h08);
    rd(8'h00, "R8 flag clear", 32'h400);
    wr(8'h04, 32'hFFFF_FFFF);
    wr(8'h00, 32'hFFFF_FFFF);
    rd(8'h10, "R5 write ignored", 32'h80);
    wr(8'h14, 32'h4000_0000);
    rd(8'h00, "R7 R8 line30", 32'h0010_0400);
    wr(8'h14, 32'h1);
    rd(8'h00, "R8 bank2 flag", 32'h0010_0600);

    wr(8'h0C, 32'hDEAD_BEEF);
    rd(8'h0C, "R11 readback", 32'hDEAD_BEEF);
    rd(8'h00, "R11 no effect", 32'h0010_0600);

    wr(8'h28, 32'h1234_5678);
    rd(8'h28, "R12 unmapped", 32'h0);
    rd(8'h14, "R12 no state", 32'h4000_0001);

    wr(8'h18, 32'hFF); wr(8'h10, '1); wr(8'h14, '1);
    rd(8'h00, "R9 all on", 32'h001F_FFFF);
    src_basic = '0; src_bank1 = '0; src_bank2 = '0;
    rd(8'h00, "R10 quiet", 32'h0);
    chk("R10 irq low", {31'b0, irq}, 32'h0);
    src_bank2 = 32'h0200_0000;
    rd(8'h00, "R7 line25", 32'h0008_0000);
    chk("R10 irq high", {31'b0, irq}, 32'h1);
    wr(8'h1C, '1); wr(8'h20, '1); wr(8'h24, '1);
    src_basic = '1; src_bank1 = '1; src_bank2 = '1;
    rd(8'h00, "R3 all off", 32'h0);

    // Randomized traffic, model compared on every cycle
    for (int i = 0; i < 400; i++) begin
      src_basic = 8'($urandom); src_bank1 = $urandom; src_bank2 = $urandom;
      if ($urandom_range(0, 1) == 1) begin
        wr(8'(4 * $urandom_range(0, 11)), $urandom);
      end
      bus_addr = 8'(4 * $urandom_range(0, 11));
      @(negedge clk);
      @(posedge clk); #1;
    end
    finish_run();
  end
endmodule